// File: doc/BRIEF.md
# Cascade Expansion Adder with Phase-Multiplexed Bus

This block is the cascade link of one convolver stage in a chain of devices. The previous device sends its 32-bit partial sum over a 16-bit expansion bus. The bus carries the lower half while the pixel clock is high and the upper half while it is low. The block rebuilds that word and can add it to the local 32-bit result. It then sends the combined sum to the next device over a 16-bit data bus that is multiplexed in the same way. The first device in a chain, or a device used alone, turns the adder off. The local result then passes straight through and the expansion bus is ignored.

When the pixel clock is too fast for phase multiplexing, a multiplex-inhibit input puts the block in a narrow mode. In that mode the expansion bus carries a single 16-bit two's-complement value per pixel, which is sign-extended before the add. Only the lower 16 bits of the sum are driven, and they are held for the whole next pixel. Gain control, field selection and overflow reporting belong to other blocks.

The block runs on one clock at twice the pixel rate. The input `pix_hi` gives the pixel-clock level for each fast cycle and must alternate high, low, high, low. A pixel period is one high cycle followed by one low cycle. The sum is formed at the clock edge that ends the low cycle.

Top module: `cascade_exp_adder`

## Requirements
- R1: A synchronous active-low reset clears the data output to 0 at the next clock edge.
- R2: In multiplexed mode (`mux_off`=0), during the low phase of pixel k+1, `dout` carries bits 31:16 of the sum formed in pixel k.
- R3: In multiplexed mode with the adder on (`add_en`=1), the word received on the expansion bus is {value in low phase, value in high phase}. During the high phase of pixel k+1, `dout` carries bits 15:0 of (local sum + that word), where the local sum is the value of pixel k.
- R4: With the adder off (`add_en`=0), the sum equals the local sum and the expansion bus has no effect on `dout`.
- R5: In narrow mode (`mux_off`=1), `dout` carries bits 15:0 of the sum of pixel k for both phases of pixel k+1. With the adder on, the expansion value is the high-phase bus value sign-extended to 32 bits.
- R6: The addition wraps modulo 2^32, and the carry out of bit 31 is dropped.
- R7: In multiplexed mode, a carry out of bit 15 of the addition reaches bit 16, so it shows in the upper half sent in the low phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at twice the pixel rate |
| rst_n | input | 1 | Synchronous active-low reset |
| pix_hi | input | 1 | Pixel-clock level during this clock cycle (1 = high phase) |
| add_en | input | 1 | Turns the expansion adder on |
| mux_off | input | 1 | Multiplex inhibit: selects narrow 16-bit mode |
| local_sum | input | 32 | Local 32-bit result, held for the whole pixel |
| exp_in | input | 16 | Expansion bus from the previous device |
| dout | output | 16 | Registered data bus to the next device |

## Verification
On every cycle the checker covers several things. It checks the reset clear and the narrow-mode hold across the high phase. It checks the narrow-mode lower-half result with the adder off and with it on. In multiplexed mode it checks the pass-through upper half with the adder off and the lower half of the reassembled sum with the adder on. Other behaviour can only be shown by the bench's sweeps. These cover the full 32-bit sum seen through both output phases, the carry from bit 15 into bit 16, and the wrap at 2^32. They also cover sign extension of a negative narrow input and the ignored expansion bus when its values are far from zero.

// File: rtl/cascade_exp_pkg.sv
// Shared types and helpers for the cascade expansion adder.
// Assumes two's-complement data throughout.
package cascade_exp_pkg;

    // Pixel-clock level for one fast clock cycle.
    typedef enum logic {
        PH_LOW  = 1'b0,
        PH_HIGH = 1'b1
    } pix_phase_e;

    // Mode of the cascade bus.
    typedef enum logic {
        BUS_SPLIT  = 1'b0,
        BUS_NARROW = 1'b1
    } bus_mode_e;

endpackage

// File: rtl/exp_bus_deser.sv
// Expansion bus receiver.
// What it does: in split mode it stores the lower half seen in the high
// phase and joins it with the upper half seen in the low phase. In narrow
// mode it sign-extends the single 16-bit value.
// Assumes: the caller uses exp_word only at the edge that ends a low phase.
module exp_bus_deser
    import cascade_exp_pkg::*;
#(
    parameter int HALF_W = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  pix_hi,
    input  logic                  mux_off,
    input  logic [HALF_W-1:0]     exp_in,
    output logic [2*HALF_W-1:0]   exp_word
);
    localparam int WORD_W = 2 * HALF_W;

    pix_phase_e          phase;
    bus_mode_e           mode;
    logic [HALF_W-1:0]   lo_half_q;
    logic [WORD_W-1:0]   split_word;
    logic [WORD_W-1:0]   narrow_word;

    assign phase = pix_phase_e'(pix_hi);
    assign mode  = bus_mode_e'(mux_off);

    // Store the lower half at the edge that ends the high phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lo_half_q <= '0;
        end else if (phase == PH_HIGH) begin
            lo_half_q <= exp_in;
        end
    end

    // Build the split word from the upper half now on the bus and the stored lower half.
    always_comb begin
        split_word = {exp_in, lo_half_q};
    end

    // Sign-extend the narrow value one bit at a time.
    genvar gi;
    generate
        for (gi = 0; gi < WORD_W; gi++) begin : g_sext
            if (gi < HALF_W) begin : g_low
                assign narrow_word[gi] = exp_in[gi];
            end else begin : g_high
                assign narrow_word[gi] = exp_in[HALF_W-1];
            end
        end
    endgenerate

    // Choose the word that matches the bus mode.
    always_comb begin
        exp_word = (mode == BUS_NARROW) ? narrow_word : split_word;
    end

endmodule

// File: rtl/exp_sum_stage.sv
// Expansion adder stage.
// What it does: forms local + expansion (or local alone when the adder is
// off), modulo 2^WORD_W. It keeps the upper half of the sum for the next
// pixel's low-phase output.
// Assumes: take is high only in the low phase, once per pixel.
module exp_sum_stage #(
    parameter int HALF_W = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  take,
    input  logic                  add_en,
    input  logic [2*HALF_W-1:0]   local_sum,
    input  logic [2*HALF_W-1:0]   exp_word,
    output logic [HALF_W-1:0]     nxt_lo,
    output logic [HALF_W-1:0]     held_hi
);
    localparam int WORD_W = 2 * HALF_W;

    logic [WORD_W-1:0] addend;
    logic [WORD_W-1:0] total;

    // Gate the expansion term with the adder enable.
    always_comb begin
        addend = add_en ? exp_word : '0;
    end

    // Add with wrap: the carry out of the top bit is not kept.
    always_comb begin
        total = local_sum + addend;
    end

    assign nxt_lo = total[HALF_W-1:0];

    // Keep the upper half of the sum formed at the end of the pixel.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held_hi <= '0;
        end else if (take) begin
            held_hi <= total[WORD_W-1:HALF_W];
        end
    end

endmodule

// File: rtl/out_bus_ser.sv
// Output bus driver.
// What it does: registers dout. At the end of a low phase it loads the
// lower half of the new sum. At the end of a high phase it loads the
// stored upper half in split mode, or keeps its value in narrow mode.
// Assumes: pix_hi alternates every clock cycle.
module out_bus_ser
    import cascade_exp_pkg::*;
#(
    parameter int HALF_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pix_hi,
    input  logic              mux_off,
    input  logic [HALF_W-1:0] nxt_lo,
    input  logic [HALF_W-1:0] held_hi,
    output logic [HALF_W-1:0] dout
);
    pix_phase_e          phase;
    bus_mode_e           mode;
    logic [HALF_W-1:0]   dout_d;

    assign phase = pix_phase_e'(pix_hi);
    assign mode  = bus_mode_e'(mux_off);

    // Choose the half that goes on the bus in the next cycle.
    always_comb begin
        unique case (phase)
            PH_LOW:  dout_d = nxt_lo;
            PH_HIGH: dout_d = (mode == BUS_NARROW) ? dout : held_hi;
            default: dout_d = dout;
        endcase
    end

    // Output register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dout <= '0;
        end else begin
            dout <= dout_d;
        end
    end

endmodule

// File: rtl/cascade_exp_adder.sv
// Cascade expansion adder, top level.
// What it does: receives a partial sum from the previous device on a
// phase-split bus, adds it to the local result if enabled, and sends the
// result on a phase-split (or narrow) output bus.
// Assumes: clk runs at twice the pixel rate, pix_hi alternates, and
// local_sum, add_en and mux_off are steady within a pixel.
module cascade_exp_adder #(
    parameter int HALF_W = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 pix_hi,
    input  logic                 add_en,
    input  logic                 mux_off,
    input  logic [2*HALF_W-1:0]  local_sum,
    input  logic [HALF_W-1:0]    exp_in,
    output logic [HALF_W-1:0]    dout
);
    localparam int WORD_W = 2 * HALF_W;

    logic [WORD_W-1:0] exp_word;
    logic [HALF_W-1:0] nxt_lo;
    logic [HALF_W-1:0] held_hi;
    logic              take;

    // The end of a low phase is the end of a pixel.
    assign take = ~pix_hi;

    exp_bus_deser #(.HALF_W(HALF_W)) u_deser (
        .clk      (clk),
        .rst_n    (rst_n),
        .pix_hi   (pix_hi),
        .mux_off  (mux_off),
        .exp_in   (exp_in),
        .exp_word (exp_word)
    );

    exp_sum_stage #(.HALF_W(HALF_W)) u_sum (
        .clk       (clk),
        .rst_n     (rst_n),
        .take      (take),
        .add_en    (add_en),
        .local_sum (local_sum),
        .exp_word  (exp_word),
        .nxt_lo    (nxt_lo),
        .held_hi   (held_hi)
    );

    out_bus_ser #(.HALF_W(HALF_W)) u_ser (
        .clk     (clk),
        .rst_n   (rst_n),
        .pix_hi  (pix_hi),
        .mux_off (mux_off),
        .nxt_lo  (nxt_lo),
        .held_hi (held_hi),
        .dout    (dout)
    );

endmodule

// File: rtl/cascade_exp_adder_chk.sv
// Checker for cascade_exp_adder. It looks only at the top-level ports.
module cascade_exp_adder_chk #(
    parameter int HALF_W = 16
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 pix_hi,
    input logic                 add_en,
    input logic                 mux_off,
    input logic [2*HALF_W-1:0]  local_sum,
    input logic [HALF_W-1:0]    exp_in,
    input logic [HALF_W-1:0]    dout
);
    localparam int WORD_W = 2 * HALF_W;

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (dout == '0));

    // R5
    narrow_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mux_off && pix_hi) |=> $stable(dout));

    // R4
    narrow_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mux_off && !add_en && !pix_hi) |=> (dout == $past(local_sum[HALF_W-1:0])));

    // R5
    narrow_add_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mux_off && add_en && !pix_hi)
        |=> (dout == $past(local_sum[HALF_W-1:0] + exp_in)));

    // R2
    split_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!mux_off && !add_en && pix_hi && $past(!pix_hi) && $past(!mux_off)
         && $past(!add_en) && $past(rst_n))
        |=> (dout == $past(local_sum[WORD_W-1:HALF_W], 2)));

    // R3
    split_lower_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!mux_off && add_en && !pix_hi && $past(pix_hi) && $past(rst_n))
        |=> (dout == HALF_W'($past(local_sum[HALF_W-1:0]) + $past(exp_in, 2))));

endmodule

bind cascade_exp_adder cascade_exp_adder_chk #(.HALF_W(HALF_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .pix_hi    (pix_hi),
    .add_en    (add_en),
    .mux_off   (mux_off),
    .local_sum (local_sum),
    .exp_in    (exp_in),
    .dout      (dout)
);

// File: tb/tb_cascade_exp_adder.sv
module tb_cascade_exp_adder;
    localparam int CLK_PERIOD = 10;
    localparam int HALF_W     = 16;
    localparam int WORD_W     = 2 * HALF_W;

    logic              clk       = 1'b0;
    logic              rst_n     = 1'b0;
    logic              pix_hi    = 1'b0;
    logic              add_en    = 1'b0;
    logic              mux_off   = 1'b0;
    logic [WORD_W-1:0] local_sum = '0;
    logic [HALF_W-1:0] exp_in    = '0;
    logic [HALF_W-1:0] dout;

    int n_cmp = 0;
    int n_bad = 0;
    logic [WORD_W-1:0] prev_sum = '0;
    string             prev_tag = "R1";

    always #(CLK_PERIOD/2) clk = ~clk;

    cascade_exp_adder #(.HALF_W(HALF_W)) dut (
        .clk(clk), .rst_n(rst_n), .pix_hi(pix_hi), .add_en(add_en),
        .mux_off(mux_off), .local_sum(local_sum), .exp_in(exp_in), .dout(dout)
    );

    task automatic check(input string req, input logic [HALF_W-1:0] got,
                         input logic [HALF_W-1:0] want);
        n_cmp++;
        if (got !== want) begin
            n_bad++;
            $display("FAIL %s: dout=%h expected %h", req, got, want);
        end
    endtask

    // Expected sum, worked out from the requirements.
    function automatic logic [WORD_W-1:0] model(input logic [WORD_W-1:0] loc,
        input logic [WORD_W-1:0] ex, input logic en, input logic moff);
        logic [WORD_W-1:0] term;
        if (moff) term = {{HALF_W{ex[HALF_W-1]}}, ex[HALF_W-1:0]};
        else      term = ex;
        return en ? loc + term : loc;
    endfunction

    // Run one pixel, and check both output phases of the pixel before it.
    task automatic pixel(input logic [WORD_W-1:0] loc, input logic [WORD_W-1:0] ex,
                         input logic en, input logic moff, input string tag);
        @(negedge clk);
        check(prev_tag, dout, prev_sum[HALF_W-1:0]);
        pix_hi = 1'b1; add_en = en; mux_off = moff; local_sum = loc;
        exp_in = ex[HALF_W-1:0];
        @(negedge clk);
        if (moff) check("R5", dout, prev_sum[HALF_W-1:0]);
        else      check((prev_tag == "R7" || prev_tag == "R6") ? prev_tag : "R2",
                        dout, prev_sum[WORD_W-1:HALF_W]);
        pix_hi = 1'b0;
        exp_in = moff ? ex[HALF_W-1:0] : ex[WORD_W-1:HALF_W];
        prev_sum = model(loc, ex, en, moff);
        if (tag != "") prev_tag = tag;
        else if (moff) prev_tag = "R5";
        else prev_tag = en ? "R3" : "R4";
    endtask

    function automatic logic [WORD_W-1:0] corner(input int i);
        case (i)
            0: return 32'h0000_0000;
            1: return 32'h0000_0001;
            2: return 32'h0000_FFFF;
            3: return 32'h0001_0000;
            4: return 32'h7FFF_FFFF;
            5: return 32'h8000_0000;
            6: return 32'hFFFF_FFFF;
            default: return 32'h1234_8765;
        endcase
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; pix_hi = 1'b0; add_en = 1'b0; local_sum = '0; exp_in = '0;
        repeat (3) @(negedge clk);
        check("R1", dout, '0);
        rst_n = 1'b1;
        prev_sum = '0;
        prev_tag = "R1";
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: got a hung run, expected completion");
        finish_run();
    end

    initial begin
        do_reset();
        // Sweep every pair of corner values in all four modes.
        for (int m = 0; m < 4; m++) begin
            for (int a = 0; a < 8; a++) begin
                for (int b = 0; b < 8; b++) begin
                    pixel(corner(a), corner(b), m[0], m[1], "");
                end
            end
        end
        // R6: the sum wraps at 2^32.
        pixel(32'hFFFF_FFFF, 32'h0000_0001, 1'b1, 1'b0, "R6");
        pixel(32'h8000_0000, 32'h8000_0000, 1'b1, 1'b0, "R6");
        // R7: a carry from the lower half shows in the upper half.
        pixel(32'h0000_FFFF, 32'h0000_0001, 1'b1, 1'b0, "R7");
        pixel(32'h1234_8000, 32'h0000_8000, 1'b1, 1'b0, "R7");
        // R5: a negative narrow input is sign-extended.
        pixel(32'h0000_0010, 32'h0000_FFFF, 1'b1, 1'b1, "R5");
        // R4: the expansion bus is ignored when the adder is off.
        pixel(32'hCAFE_0123, 32'hFFFF_FFFF, 1'b0, 1'b0, "R4");
        pixel(32'h0000_0000, 32'hA5A5_5A5A, 1'b0, 1'b0, "R4");
        // Random pixels, with the mode changing between them.
        for (int i = 0; i < 300; i++) begin
            pixel(WORD_W'($urandom), WORD_W'($urandom), 1'($urandom), 1'($urandom), "");
        end
        // R1: a reset in the middle of a run clears the output.
        pixel(32'hDEAD_BEEF, 32'h0101_0101, 1'b1, 1'b0, "");
        do_reset();
        pixel(32'h0000_0042, 32'h0000_0001, 1'b1, 1'b0, "");
        pixel(32'h0000_0000, 32'h0000_0000, 1'b0, 1'b0, "");
        pixel(32'h0000_0000, 32'h0000_0000, 1'b0, 1'b0, "");
        finish_run();
    end

endmodule